// File: doc/BRIEF.md
# Frame-Synchronised SPI Master

This block is an SPI master that generates the serial clock but never starts a word on its own. While it is enabled, the serial clock runs continuously at a programmable fraction of the system clock. The block waits until an external frame-sync input is seen at its active level on the clock's sample edge. The word is then launched on the following transmit edge, most significant bit first.

Software reaches the block through a small word-wide register port with three addresses: a control word, a data buffer and a status word. A write to the data buffer queues a word. That word moves into the internal shift register only when a frame begins, so the shift register has no direct write path. If nothing was queued, a frame shifts out zeros. Each finished word raises an interrupt flag and is offered in the receive buffer. A word that finishes while the previous one is still unread is dropped and flagged as an overflow. A receive-only option releases the serial data output, and incoming data is still captured.

Top module: `fsync_spi_master`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the control word and the status word read 0, irq_o is 0, sck_o is 0 and sdo_oe_o is 0.
- R2: Register addresses are 0 for control, 1 for data and 2 for status. The control fields are: bit 0 enable, bit 1 clock polarity (idle level of sck_o), bit 2 clock edge, bit 3 sample phase, bit 4 frame polarity, bits 6:5 word width code, bit 7 output disable and bits 15:8 divider. A control read returns the stored fields.
- R3: While enabled, sck_o toggles once every divider+1 system clock cycles. Once enable has been 0 for two cycles, sck_o rests at the clock polarity level.
- R4: A frame starts only when fsync_i equals the frame polarity bit (1 means active high, 0 means active low) at a sample edge. The first data bit then appears on the next launch edge. Clock edge 0 launches data on the active-to-idle transition and samples on idle-to-active; clock edge 1 does the reverse. While fsync_i stays inactive, no word is transferred.
- R5: The width codes select 8 bits (00), 16 bits (01), 32 bits (10) and 8 bits (11). The low bits of the queued word are sent most significant bit first on sdo_o, one bit per launch edge.
- R6: A frame that begins with no word queued since the last frame shifts out all zeros.
- R7: With sample phase 0, sdi_i is captured on the sample edges. With sample phase 1, it is captured on the launch edge that ends each bit. The finished word appears zero-extended at the data address, and the status receive-full bit (bit 0) is set. A read of the data address clears receive-full.
- R8: At the end of each word, status bit 2 and irq_o are set. Writing a 1 to status bit 2 clears both.
- R9: When a word finishes while receive-full is set, status bit 1 (overflow) is set and the earlier received word is kept. Writing a 1 to status bit 1 clears the overflow.
- R10: With the output disable bit set, sdo_oe_o and sdo_o stay 0 during frames, and the word is still received and flagged.
- R11: While enable is 1, control writes leave the clock polarity and clock edge bits unchanged.
- R12: Clearing enable stops any word in progress and clears receive-full, overflow, the interrupt flag and any queued word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acts on the data address) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_o | output | 1 | Word-complete interrupt flag |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial data out enable |
| sdi_i | input | 1 | Serial data in |
| fsync_i | input | 1 | External frame-sync input |

## Verification
The bench plays the slave and draws random combinations of divider, polarity, edge, sample phase, frame polarity, width and output disable. It goes after the point where a frame starts. A design that launches on the same edge that sampled the frame pulse, or that ignores the frame polarity, either sends a shifted word or starts with no pulse at all. Frames with no word queued expose a design that resends stale buffer contents instead of zeros. End-of-bit sampling catches a receiver that is off by one bit. A back-to-back pair of words without a read shows whether a design overwrites the unread word instead of flagging the overflow.

// File: rtl/fsync_spi_pkg.sv
// Shared constants for the frame-synchronised SPI master: register
// addresses, control field positions and the width-code decoder.
package fsync_spi_pkg;
    localparam int WORD_MAX = 32;
    localparam int CNT_W    = $clog2(WORD_MAX + 1);

    localparam logic [1:0] ADR_CTL  = 2'd0;
    localparam logic [1:0] ADR_DATA = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;

    localparam int B_EN    = 0;
    localparam int B_CPOL  = 1;
    localparam int B_CPHA  = 2;
    localparam int B_SMP   = 3;
    localparam int B_FPOL  = 4;
    localparam int B_WID   = 5;
    localparam int B_QUIET = 7;
    localparam int B_DIV   = 8;

    typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

    // Word length selected by the 2-bit width code; the reserved code gives 8.
    function automatic logic [CNT_W-1:0] word_len(input logic [1:0] code);
        case (code)
            2'b01:   word_len = CNT_W'(16);
            2'b10:   word_len = CNT_W'(32);
            default: word_len = CNT_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/spi_clk_div.sv
// Serial clock generator. It divides clk by 2*(div_i+1) while en_i is high
// and flags the idle-to-active (lead) and active-to-idle (trail)
// transitions in the cycle in which sck_o changes. Assumes div_i is
// constant while en_i is high.
module spi_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             cpol_i,
    output logic             lead_o,
    output logic             trail_o,
    output logic             sck_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             ph_q;
    logic             tick;

    assign tick    = en_i && (cnt_q == div_i);
    assign lead_o  = tick && !ph_q;
    assign trail_o = tick && ph_q;
    assign sck_o   = ph_q ^ cpol_i;

    // Half-period counter and clock phase; parked at the idle phase when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (cnt_q == div_i) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_frame_engine.sv
// Word engine. It waits for an active frame sync on a sample edge, loads
// the queued word left-aligned, drives one bit per launch edge and
// captures sdi_i either on sample edges or on the next launch edge. Assumes
// launch_i and samp_i are never high in the same cycle.
module spi_frame_engine
    import fsync_spi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                launch_i,
    input  logic                samp_i,
    input  logic                fsync_act_i,
    input  logic [WORD_MAX-1:0] load_word_i,
    input  logic [CNT_W-1:0]    nbits_i,
    input  logic                smp_end_i,
    input  logic                quiet_i,
    input  logic                sdi_i,
    output logic                start_o,
    output logic                done_o,
    output logic                busy_o,
    output logic                sdo_o,
    output logic [WORD_MAX-1:0] rx_o
);
    eng_state_t          st_q;
    logic [WORD_MAX-1:0] sh_q, rx_q;
    logic [CNT_W-1:0]    lcnt_q, scnt_q;
    logic                sdo_q;

    assign start_o = en_i && (st_q == ENG_IDLE) && samp_i && fsync_act_i;
    assign done_o  = (st_q == ENG_SHIFT) && (scnt_q == nbits_i);
    assign busy_o  = (st_q == ENG_SHIFT);
    assign sdo_o   = sdo_q && !quiet_i;
    assign rx_o    = rx_q;

    // Frame sequencing: start on sync, shift out on launch, capture on the chosen edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            st_q   <= ENG_IDLE;
            sh_q   <= '0;
            rx_q   <= '0;
            lcnt_q <= '0;
            scnt_q <= '0;
            sdo_q  <= 1'b0;
        end else if (st_q == ENG_IDLE) begin
            sdo_q <= 1'b0;
            if (samp_i && fsync_act_i) begin
                st_q   <= ENG_SHIFT;
                sh_q   <= load_word_i << (CNT_W'(WORD_MAX) - nbits_i);
                lcnt_q <= '0;
                scnt_q <= '0;
            end
        end else if (scnt_q == nbits_i) begin
            st_q <= ENG_IDLE;
        end else begin
            if (launch_i) begin
                if (lcnt_q != nbits_i) begin
                    sdo_q  <= sh_q[WORD_MAX-1];
                    sh_q   <= {sh_q[WORD_MAX-2:0], 1'b0};
                    lcnt_q <= lcnt_q + 1'b1;
                end
                if (smp_end_i && lcnt_q != '0) begin
                    rx_q   <= {rx_q[WORD_MAX-2:0], sdi_i};
                    scnt_q <= scnt_q + 1'b1;
                end
            end
            if (samp_i && !smp_end_i && scnt_q < lcnt_q) begin
                rx_q   <= {rx_q[WORD_MAX-2:0], sdi_i};
                scnt_q <= scnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsync_spi_master.sv
// Frame-synchronised SPI master top. It holds the control, data and status
// registers and connects the clock divider to the word engine. Assumes
// fsync_i and sdi_i are already synchronous to clk and DIV_W <= 24.
module fsync_spi_master
    import fsync_spi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o,
    output logic        sck_o,
    output logic        sdo_o,
    output logic        sdo_oe_o,
    input  logic        sdi_i,
    input  logic        fsync_i
);
    localparam int CTL_W = B_DIV + DIV_W;

    logic                en_q, cpol_q, cpha_q, smp_q, fpol_q, quiet_q;
    logic [1:0]          wid_q;
    logic [DIV_W-1:0]    div_q;
    logic [WORD_MAX-1:0] tx_buf_q, rx_buf_q, eng_rx, rx_mask;
    logic                tx_valid_q, rx_full_q, ovf_q, irq_q;
    logic                lead, trail, launch, samp;
    logic                eng_start, eng_done, eng_busy;
    logic [CNT_W-1:0]    nbits;
    logic [CTL_W-1:0]    ctl_vec;
    logic                wr_ctl, wr_data, wr_stat, rd_data, full_eff;

    assign wr_ctl   = reg_wr && reg_addr == ADR_CTL;
    assign wr_data  = reg_wr && reg_addr == ADR_DATA;
    assign wr_stat  = reg_wr && reg_addr == ADR_STAT;
    assign rd_data  = reg_rd && reg_addr == ADR_DATA;
    assign full_eff = rx_full_q && !rd_data;
    assign nbits    = word_len(wid_q);
    assign rx_mask  = {WORD_MAX{1'b1}} >> (CNT_W'(WORD_MAX) - nbits);
    assign launch   = cpha_q ? lead : trail;
    assign samp     = cpha_q ? trail : lead;
    assign irq_o    = irq_q;
    assign sdo_oe_o = en_q && !quiet_q;
    assign ctl_vec  = {div_q, quiet_q, wid_q, fpol_q, smp_q, cpha_q, cpol_q, en_q};

    spi_clk_div #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en_i(en_q), .div_i(div_q), .cpol_i(cpol_q),
        .lead_o(lead), .trail_o(trail), .sck_o(sck_o)
    );

    spi_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .en_i(en_q), .launch_i(launch), .samp_i(samp),
        .fsync_act_i(fsync_i == fpol_q),
        .load_word_i(tx_valid_q ? tx_buf_q : '0),
        .nbits_i(nbits), .smp_end_i(smp_q), .quiet_i(quiet_q), .sdi_i(sdi_i),
        .start_o(eng_start), .done_o(eng_done), .busy_o(eng_busy),
        .sdo_o(sdo_o), .rx_o(eng_rx)
    );

    // Control register; clock polarity and edge are locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {en_q, cpol_q, cpha_q, smp_q, fpol_q, quiet_q} <= '0;
            wid_q <= '0;
            div_q <= '0;
        end else if (wr_ctl) begin
            en_q    <= reg_wdata[B_EN];
            smp_q   <= reg_wdata[B_SMP];
            fpol_q  <= reg_wdata[B_FPOL];
            wid_q   <= reg_wdata[B_WID +: 2];
            quiet_q <= reg_wdata[B_QUIET];
            div_q   <= reg_wdata[B_DIV +: DIV_W];
            if (!en_q) begin
                cpol_q <= reg_wdata[B_CPOL];
                cpha_q <= reg_wdata[B_CPHA];
            end
        end
    end

    // Transmit buffer: a write queues a word, a frame start consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf_q   <= '0;
            tx_valid_q <= 1'b0;
        end else if (wr_data) begin
            tx_buf_q   <= reg_wdata;
            tx_valid_q <= en_q;
        end else if (eng_start || !en_q) begin
            tx_valid_q <= 1'b0;
        end
    end

    // Receive buffer, overflow and interrupt flags with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf_q  <= '0;
            rx_full_q <= 1'b0;
            ovf_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else if (!en_q) begin
            rx_full_q <= 1'b0;
            ovf_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            rx_full_q <= full_eff;
            if (wr_stat && reg_wdata[1]) ovf_q <= 1'b0;
            if (wr_stat && reg_wdata[2]) irq_q <= 1'b0;
            if (eng_done) begin
                irq_q <= 1'b1;
                if (full_eff) begin
                    ovf_q <= 1'b1;
                end else begin
                    rx_buf_q  <= eng_rx & rx_mask;
                    rx_full_q <= 1'b1;
                end
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            ADR_CTL:  reg_rdata = 32'(ctl_vec);
            ADR_DATA: reg_rdata = rx_buf_q;
            ADR_STAT: reg_rdata = {29'd0, irq_q, ovf_q, rx_full_q};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fsync_spi_master_chk.sv
// Property checker for fsync_spi_master, attached by bind. It observes
// registers and engine handshakes and drives nothing.
module fsync_spi_master_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cpol,
    input logic sck,
    input logic irq,
    input logic done,
    input logic busy,
    input logic ovf,
    input logic rx_full,
    input logic quiet,
    input logic sdo,
    input logic sdo_oe
);
    AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (sck == cpol)); // R3
    AST_CLK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(cpol)); // R11
    AST_IRQ_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done)); // R8
    AST_OVF_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(rx_full)); // R9
    AST_QUIET_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (!sdo_oe && !sdo)); // R10
    AST_STOP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> !busy); // R12
endmodule

bind fsync_spi_master fsync_spi_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .cpol(cpol_q), .sck(sck_o),
    .irq(irq_q), .done(eng_done), .busy(eng_busy), .ovf(ovf_q),
    .rx_full(rx_full_q), .quiet(quiet_q), .sdo(sdo_o), .sdo_oe(sdo_oe_o)
);

// File: tb/test_fsync_spi_master.sv
// Bench for fsync_spi_master: acts as the frame-sync source and the slave,
// mixing seeded random configurations with directed corner cases.
module test_fsync_spi_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq_o, sck_o, sdo_o, sdo_oe_o;
    logic        sdi_i = 1'b0, fsync_i = 1'b1;
    logic        sck_before = 1'b0;
    bit          cur_cpol, cur_cpha, cur_fpol;
    int          n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;
    always @(posedge clk) sck_before <= sck_o;

    fsync_spi_master i_fsync_spi_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .sck_o(sck_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .sdi_i(sdi_i), .fsync_i(fsync_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic int wlen(input logic [1:0] code);
        return (code == 2'b01) ? 16 : (code == 2'b10) ? 32 : 8;
    endfunction

    function automatic logic [31:0] wmask(input int n);
        return 32'hFFFF_FFFF >> (32 - n);
    endfunction

    function automatic logic [31:0] ctl_word(input bit en, input bit cpol, input bit cpha,
            input bit smp, input bit fpol, input logic [1:0] wid, input bit quiet,
            input logic [7:0] div);
        return {16'd0, div, quiet, wid, fpol, smp, cpha, cpol, en};
    endfunction

    // Waits for the next launch (want=1) or sample (want=0) edge seen on sck_o.
    task automatic wait_edge(input bit want);
        bit got = 0;
        while (!got) begin
            @(negedge clk);
            if (sck_o != sck_before) begin
                bit lead = (sck_o != cur_cpol);
                if ((cur_cpha ? lead : !lead) == want) got = 1;
            end
        end
    endtask

    task automatic cfg(input logic [7:0] div, input bit cpol, input bit cpha, input bit smp,
            input bit fpol, input logic [1:0] wid, input bit quiet);
        cur_cpol = cpol; cur_cpha = cpha; cur_fpol = fpol;
        fsync_i = !fpol;
        wr(2'd0, ctl_word(0, cpol, cpha, smp, fpol, wid, quiet, div));
        wr(2'd0, ctl_word(1, cpol, cpha, smp, fpol, wid, quiet, div));
    endtask

    // One frame: pulse frame sync, serve slave bits, collect master bits.
    task automatic run_frame(input logic [31:0] slave, input int n,
            output logic [31:0] seen, output bit quiet_ok);
        int guard = 0;
        seen = '0; quiet_ok = 1;
        wait_edge(0);
        fsync_i = cur_fpol;
        wait_edge(0);
        fsync_i = !cur_fpol;
        for (int k = 0; k < n; k++) begin
            wait_edge(1);
            sdi_i = slave[n-1-k];
            wait_edge(0);
            seen = {seen[30:0], sdo_o};
            if (sdo_o || sdo_oe_o) quiet_ok = 0;
        end
        while (!irq_o && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, seen, slave, tx;
        bit q_ok;
        int cnt;
        void'($urandom(32'd2718));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 sck", sck_o, 0);
        chk("R1 oe", sdo_oe_o, 0);
        rd(2'd0, d); chk("R1 ctl", d, 0);
        rd(2'd2, d); chk("R1 stat", d, 0);

        // R3: sck half period is div+1 cycles; R2: control readback
        cfg(8'd2, 1, 0, 0, 0, 2'b00, 0);
        rd(2'd0, d); chk("R2 ctl readback", d, ctl_word(1, 1, 0, 0, 0, 2'b00, 0, 8'd2));
        wait_edge(0);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (sck_o == sck_before);
        chk("R3 half period", cnt, 3);
        // R11: clock polarity and edge locked while enabled
        wr(2'd0, ctl_word(1, 0, 1, 0, 0, 2'b00, 0, 8'd2));
        rd(2'd0, d); chk("R11 cpol/cpha locked", d[2:1], 2'b01);
        // R3: parked at idle level when disabled
        wr(2'd0, ctl_word(0, 1, 0, 0, 0, 2'b00, 0, 8'd2));
        repeat (3) @(negedge clk);
        chk("R3 parked", sck_o, 1);

        // R4: inactive frame sync never starts a word
        cfg(8'd0, 0, 0, 0, 1, 2'b00, 0);
        wr(2'd1, 32'hA5);
        fsync_i = 1'b0;
        repeat (60) @(negedge clk);
        chk("R4 no frame irq", irq_o, 0);
        rd(2'd2, d); chk("R4 no frame stat", d, 0);

        // Random frames: R4 R5 R6 R7 R8 R10
        for (int it = 0; it < 28; it++) begin
            logic [1:0] wid = 2'($urandom_range(0, 3));
            bit cpol = 1'($urandom), cpha = 1'($urandom), smp = 1'($urandom);
            bit fpol = 1'($urandom), quiet = ($urandom_range(0, 4) == 0);
            bit loaded = ($urandom_range(0, 3) != 0);
            int n = wlen(wid);
            cfg(8'($urandom_range(0, 3)), cpol, cpha, smp, fpol, wid, quiet);
            tx = $urandom; slave = $urandom;
            if (loaded) wr(2'd1, tx);
            run_frame(slave, n, seen, q_ok);
            chk("R8 irq set", irq_o, 1);
            if (quiet) chk("R10 output quiet", q_ok, 1);
            else if (loaded) chk("R5 tx msb-first", seen, tx & wmask(n));
            else chk("R6 zeros sent", seen, 0);
            rd(2'd2, d); chk("R7 stat full+irq", d, 32'd5);
            rd(2'd1, d); chk("R7 rx word", d, slave & wmask(n));
            wr(2'd2, 32'd4);
            @(negedge clk);
            chk("R8 irq cleared", irq_o, 0);
        end

        // R9: second word while unread -> overflow, first word kept
        cfg(8'd1, 0, 1, 0, 0, 2'b00, 0);
        run_frame(32'h3C, 8, seen, q_ok);
        run_frame(32'hC3, 8, seen, q_ok);
        rd(2'd2, d); chk("R9 overflow stat", d, 32'd7);
        rd(2'd1, d); chk("R9 first word kept", d, 32'h3C);
        wr(2'd2, 32'd2);
        rd(2'd2, d); chk("R9 overflow cleared", d, 32'd4);

        // R12: clearing enable clears flags
        run_frame(32'h81, 8, seen, q_ok);
        wr(2'd0, ctl_word(0, 0, 1, 0, 0, 2'b00, 0, 8'd1));
        rd(2'd2, d); chk("R12 flags cleared", d, 0);
        chk("R12 irq low", irq_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule